// File: doc/BRIEF.md
# I2C Bus Stall Recovery Unit

This unit sits beside an I2C master controller and rescues the bus when it hangs. A saturating counter measures how long SCL has been held low. When that time passes a fixed limit, or when the controller reports a lost arbitration, the unit takes over the recovery. It resets the controller's internal state and releases both lines. After a settling delay it examines the wires.

A low SCL at that point means another device is holding the clock. The unit cannot clear this, so it gives up with an error. A low SDA means a target is probably part-way through a byte. The unit then issues single SCL pulses, with low and high times that match 400 kbit/s operation, and checks SDA after each high phase. It stops once SDA is free, or reports an error after nine pulses. Once SDA is free, the unit finishes in one of two ways. If the controller still considers the bus busy, it sends a stop condition. Otherwise it simply returns to idle.

The outcome is a one-cycle done pulse that carries a success/error bit. Line outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2c_bus_recovery`

## Requirements
- R1: While idle, recovery starts (ctrl_reset_o high) after the clock edge on which scl_i has been sampled low on 2^TO_WIDTH-1 consecutive edges; any edge with scl_i high clears the count.
- R2: A one-cycle arb_lost_i in idle starts recovery on the next edge; arb_lost_i while recovery is running has no effect on the result or the pulse count, and no second recovery starts.
- R3: ctrl_reset_o stays high for exactly T_REL cycles, and both scl_oe_o and sda_oe_o stay 0 during that time.
- R4: If scl_i is low when the release delay ends, the sequence ends with ok_o=0 and no SCL pulse.
- R5: While sda_i is low, each pulse drives scl_oe_o=1 for exactly T_LOW cycles and then releases SCL for T_HIGH cycles in which scl_i is high. SDA is sampled after each high phase, so a target that frees SDA on its K-th rising SCL edge gets exactly K pulses.
- R6: If sda_i is still low after the ninth pulse, the sequence ends with ok_o=0, after exactly 9 pulses and with no stop.
- R7: If the SCL low-time limit is reached while pulsing, because SCL is held low during a high phase, the sequence ends with ok_o=0.
- R8: With bus_busy_i=1 once SDA is free, a stop is sent. SCL is pulled low first. SDA is then pulled low while SCL stays low, for a total SCL low time of T_LOW+1 cycles. SCL is then released, and SDA is released last. With bus_busy_i=0, sda_oe_o never rises.
- R9: done_o is a single-cycle pulse that ends each sequence, with ok_o=1 for success and 0 for error; done_o and ctrl_reset_o are 0 out of reset.
- R10: If sda_i is already high when the release delay ends, no SCL pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| arb_lost_i | input | 1 | Controller lost arbitration (pulse) |
| bus_busy_i | input | 1 | Controller sees the bus as busy |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ctrl_reset_o | output | 1 | Internal reset to the controller |
| done_o | output | 1 | Sequence finished (one cycle) |
| ok_o | output | 1 | Result with done_o: 1 success, 0 error |

## Verification
The assertions assume that scl_i and sda_i follow the open-drain outputs. When the unit pulls a line, the line reads low on the next edge. A released line reads high unless the bench's stuck-clock or stalled-target models hold it. The bench builds both lines as wired-AND nets of the unit's enables and those models. The target model frees SDA only on rising SCL edges. The SCL hold is applied or removed at falling clock edges, so the lines never glitch within a cycle.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_CHK,
    ST_LO,
    ST_HI,
    ST_SMP,
    ST_STP_PRE,
    ST_STP_LO,
    ST_STP_HI
  } rcv_state_e;
endpackage

// File: rtl/i2c_rcv_low_timer.sv
module i2c_rcv_low_timer #(
  parameter int TO_WIDTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam logic [TO_WIDTH-1:0] CNT_MAX = '1;

  logic [TO_WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || scl_i)     cnt_q <= '0;
    else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  // fires once per low stretch, saturation keeps it from repeating
  assign hit_o = !scl_i && (cnt_q == CNT_MAX - 1'b1);

  a_r1_hit_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !$past(scl_i));
endmodule

// File: rtl/i2c_rcv_phase_timer.sv
module i2c_rcv_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  output logic          zero_o
);
  logic [CW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tmr_q <= '0;
    else if (load_i)                tmr_q <= load_val_i;
    else if (run_i && tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  assign zero_o = (tmr_q == '0);
endmodule

// File: rtl/i2c_rcv_fsm.sv
module i2c_rcv_fsm
  import i2c_rcv_pkg::*;
#(
  parameter int T_REL      = 8,
  parameter int T_LOW      = 17,
  parameter int T_HIGH     = 8,
  parameter int MAX_PULSES = 9,
  parameter int CW         = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          arb_lost_i,
  input  logic          bus_busy_i,
  input  logic          to_hit_i,
  input  logic          tmr_zero_i,
  output logic          tmr_ld_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          tmr_run_o,
  output logic          to_clr_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          ctrl_reset_o,
  output logic          done_o,
  output logic          ok_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);

  rcv_state_e    st_q, st_d;
  logic [PW-1:0] pcnt_q;
  logic          inc_p, clr_p, fin, fin_ok;
  logic          done_q, ok_q;

  always_comb begin
    st_d      = st_q;
    tmr_ld_o  = 1'b0;
    tmr_val_o = '0;
    tmr_run_o = 1'b0;
    to_clr_o  = 1'b0;
    inc_p     = 1'b0;
    clr_p     = 1'b0;
    fin       = 1'b0;
    fin_ok    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (to_hit_i || arb_lost_i) begin
        st_d      = ST_RST;
        tmr_ld_o  = 1'b1;
        tmr_val_o = CW'(T_REL - 1);
        to_clr_o  = 1'b1;
      end
      ST_RST: begin
        tmr_run_o = 1'b1;
        if (tmr_zero_i) st_d = ST_CHK;
      end
      ST_CHK: begin
        clr_p = 1'b1;
        if (!scl_i) fin = 1'b1;
        else if (sda_i) begin
          if (bus_busy_i) st_d = ST_STP_PRE;
          else begin fin = 1'b1; fin_ok = 1'b1; end
        end else begin
          st_d      = ST_LO;
          tmr_ld_o  = 1'b1;
          tmr_val_o = CW'(T_LOW - 1);
        end
      end
      ST_LO: begin
        tmr_run_o = 1'b1;
        if (to_hit_i) fin = 1'b1;
        else if (tmr_zero_i) begin
          st_d      = ST_HI;
          tmr_ld_o  = 1'b1;
          tmr_val_o = CW'(T_HIGH - 1);
          inc_p     = 1'b1;
        end
      end
      ST_HI: begin
        tmr_run_o = scl_i;  // stretched clock stalls the high phase
        if (to_hit_i) fin = 1'b1;
        else if (tmr_zero_i && scl_i) st_d = ST_SMP;
      end
      ST_SMP: begin
        if (sda_i) begin
          if (bus_busy_i) st_d = ST_STP_PRE;
          else begin fin = 1'b1; fin_ok = 1'b1; end
        end else if (pcnt_q == PW'(MAX_PULSES)) fin = 1'b1;
        else begin
          st_d      = ST_LO;
          tmr_ld_o  = 1'b1;
          tmr_val_o = CW'(T_LOW - 1);
        end
      end
      ST_STP_PRE: begin
        st_d      = ST_STP_LO;
        tmr_ld_o  = 1'b1;
        tmr_val_o = CW'(T_LOW - 1);
      end
      ST_STP_LO: begin
        tmr_run_o = 1'b1;
        if (to_hit_i) fin = 1'b1;
        else if (tmr_zero_i) begin
          st_d      = ST_STP_HI;
          tmr_ld_o  = 1'b1;
          tmr_val_o = CW'(T_HIGH - 1);
        end
      end
      ST_STP_HI: begin
        tmr_run_o = scl_i;
        if (to_hit_i) fin = 1'b1;
        else if (tmr_zero_i && scl_i) begin fin = 1'b1; fin_ok = 1'b1; end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pcnt_q <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      ok_q   <= fin && fin_ok;
      if (clr_p)      pcnt_q <= '0;
      else if (inc_p) pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign scl_oe_o     = (st_q == ST_LO) || (st_q == ST_STP_PRE) || (st_q == ST_STP_LO);
  assign sda_oe_o     = (st_q == ST_STP_LO) || (st_q == ST_STP_HI);
  assign ctrl_reset_o = (st_q == ST_RST);
  assign done_o       = done_q;
  assign ok_o         = ok_q;

  a_r2_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_reset_o) |-> $past(st_q) == ST_IDLE);
  a_r3_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_reset_o |-> !scl_oe_o && !sda_oe_o);
  a_r4_stuck_scl_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHK && !scl_i) |=> done_o && !ok_o);
  a_r6_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= PW'(MAX_PULSES));
  a_r8_sda_under_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> scl_oe_o && $past(scl_oe_o));
  a_r8_sda_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_oe_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
  parameter int TO_WIDTH   = 16,
  parameter int T_REL      = 8,
  parameter int T_LOW      = 17,
  parameter int T_HIGH     = 8,
  parameter int MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic arb_lost_i,
  input  logic bus_busy_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic ctrl_reset_o,
  output logic done_o,
  output logic ok_o
);
  localparam int TMAX_LH = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int TMAX    = (T_REL > TMAX_LH) ? T_REL : TMAX_LH;
  localparam int CW      = $clog2(TMAX + 1);

  logic          to_hit, to_clr, tmr_ld, tmr_run, tmr_zero;
  logic [CW-1:0] tmr_val;

  i2c_rcv_low_timer #(.TO_WIDTH(TO_WIDTH)) u_low_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .clr_i  (to_clr),
    .hit_o  (to_hit)
  );

  i2c_rcv_phase_timer #(.CW(CW)) u_phase_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_ld),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .zero_o     (tmr_zero)
  );

  i2c_rcv_fsm #(
    .T_REL(T_REL), .T_LOW(T_LOW), .T_HIGH(T_HIGH),
    .MAX_PULSES(MAX_PULSES), .CW(CW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .arb_lost_i   (arb_lost_i),
    .bus_busy_i   (bus_busy_i),
    .to_hit_i     (to_hit),
    .tmr_zero_i   (tmr_zero),
    .tmr_ld_o     (tmr_ld),
    .tmr_val_o    (tmr_val),
    .tmr_run_o    (tmr_run),
    .to_clr_o     (to_clr),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .ctrl_reset_o (ctrl_reset_o),
    .done_o       (done_o),
    .ok_o         (ok_o)
  );
endmodule

// File: tb/i2c_bus_recovery_bench.sv
`timescale 1ns/1ps
module i2c_bus_recovery_bench;
  localparam int TO_W = 8;
  localparam int TREL = 5;
  localparam int TLOW = 4;
  localparam int THI  = 3;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n, arb, busy, ext_hold;
  logic scl_oe, sda_oe, ctrl_rst, done, ok;
  logic scl_w, sda_w;
  int   scl_rises = 0;
  int   base = 0, k_hold = 0;
  int   checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  assign scl_w = !scl_oe && !ext_hold;
  assign sda_w = !sda_oe && !((scl_rises - base) < k_hold);

  always @(posedge scl_w) scl_rises <= scl_rises + 1;

  i2c_bus_recovery #(.TO_WIDTH(TO_W), .T_REL(TREL), .T_LOW(TLOW),
                     .T_HIGH(THI), .MAX_PULSES(MAXP)) u_i2c_bus_recovery (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .arb_lost_i(arb), .bus_busy_i(busy), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .ctrl_reset_o(ctrl_rst), .done_o(done), .ok_o(ok));

  function automatic int exp_pulses(int k);
    return (k > MAXP) ? MAXP : k;
  endfunction
  function automatic bit exp_ok(int k);
    return k <= MAXP;
  endfunction
  function automatic bit exp_stop(int k, bit b);
    return (k <= MAXP) && b;
  endfunction

  task automatic check(bit cond, string req, int act, int expv);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // watches one sequence until done_o
  task automatic observe(int exp_rst, output int npul, output bit got_ok,
                         output bit stopped, output bit seen);
    int  run = 0, rst_cyc = 0;
    bit  sda_in_run = 0, prev = 0, quiet = 1, widths = 1, dpulse = 1;
    npul = 0; got_ok = 0; stopped = 0; seen = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (ctrl_rst) begin
        rst_cyc++;
        if (scl_oe || sda_oe) quiet = 0;
      end
      if (scl_oe) begin
        run++;
        if (sda_oe) sda_in_run = 1;
      end else if (prev) begin
        if (sda_in_run) begin
          if (run != TLOW + 1) widths = 0;
        end else begin
          npul++;
          if (run != TLOW) widths = 0;
        end
        run = 0; sda_in_run = 0;
      end
      if (sda_oe) stopped = 1;
      prev = scl_oe;
      if (done) begin
        got_ok = ok; seen = 1;
        @(negedge clk);
        if (done) dpulse = 0;
        break;
      end
    end
    check(seen, "R9 done reached", seen, 1);
    check(rst_cyc == exp_rst, "R3 reset length", rst_cyc, exp_rst);
    check(quiet, "R3 lines released in reset", quiet, 1);
    check(widths, "R5/R8 scl low width", widths, 1);
    check(dpulse, "R9 done single cycle", dpulse, 1);
  endtask

  task automatic run_case(int k, bit b, string tag);
    int np; bit gok, st, sn;
    base = scl_rises; k_hold = k; busy = b;
    arb = 1'b1;
    fork
      observe(TREL, np, gok, st, sn);
      begin @(negedge clk); arb = 1'b0; end
    join
    check(np == exp_pulses(k), {tag, " pulse count"}, np, exp_pulses(k));
    check(gok == exp_ok(k), {tag, " result"}, gok, exp_ok(k));
    check(st == exp_stop(k, b), {tag, " stop"}, st, exp_stop(k, b));
    k_hold = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int np, n; bit gok, st, sn, again;
    void'($urandom(32'd1234));
    rst_n = 1'b0; arb = 1'b0; busy = 1'b0; ext_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !ctrl_rst, "R9 reset state", {done, ctrl_rst}, 0);
    check(!scl_oe && !sda_oe, "R3 reset outputs", {scl_oe, sda_oe}, 0);

    run_case(0, 1'b0, "R10 sda free idle");
    run_case(0, 1'b1, "R8 sda free busy");
    run_case(1, 1'b0, "R5 one pulse");
    run_case(9, 1'b1, "R5 nine pulses");
    run_case(10, 1'b1, "R6 pulse limit");
    run_case(12, 1'b0, "R6 pulse limit idle");
    for (int i = 0; i < 20; i++) begin
      int kk; bit bb;
      kk = int'($urandom_range(0, 11));
      bb = 1'($urandom_range(0, 1));
      run_case(kk, bb, "R5 random");
    end

    // R1: a short low stretch does not trigger
    ext_hold = 1'b1;
    repeat (200) @(negedge clk);
    ext_hold = 1'b0;
    again = 0;
    repeat (300) begin @(negedge clk); if (ctrl_rst) again = 1; end
    check(!again, "R1 short low no trigger", again, 0);

    // R1 + R4: stuck clock triggers by timeout, then errors
    ext_hold = 1'b1; n = 0;
    while (!ctrl_rst && n < 1000) begin @(negedge clk); n++; end
    check(n == (1 << TO_W) - 1, "R1 timeout edges", n, (1 << TO_W) - 1);
    observe(TREL - 1, np, gok, st, sn);
    ext_hold = 1'b0;
    check(!gok, "R4 stuck scl result", gok, 0);
    check(np == 0, "R4 stuck scl pulses", np, 0);
    repeat (5) @(negedge clk);

    // R7: clock held low during pulsing
    base = scl_rises; k_hold = 6; busy = 1'b1; arb = 1'b1;
    fork
      observe(TREL, np, gok, st, sn);
      begin @(negedge clk); arb = 1'b0; end
      begin @(posedge scl_oe); @(posedge scl_oe); ext_hold = 1'b1; end
    join
    ext_hold = 1'b0; k_hold = 0;
    check(!gok, "R7 timeout in pulsing result", gok, 0);
    check(np == 2, "R7 pulses before stall", np, 2);
    check(!st, "R7 no stop", st, 0);
    repeat (5) @(negedge clk);

    // R2: arbitration loss during recovery is ignored
    base = scl_rises; k_hold = 5; busy = 1'b0; arb = 1'b1;
    fork
      observe(TREL, np, gok, st, sn);
      begin
        @(negedge clk); arb = 1'b0;
        @(posedge scl_oe); @(negedge clk); arb = 1'b1;
        @(negedge clk); arb = 1'b0;
      end
    join
    k_hold = 0;
    check(gok, "R2 ignored trigger result", gok, 1);
    check(np == 5, "R2 ignored trigger pulses", np, 5);
    again = 0;
    repeat (50) begin @(negedge clk); if (ctrl_rst) again = 1; end
    check(!again, "R2 no second recovery", again, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule